// File: doc/BRIEF.md
# Page Program Load Buffer

This block gathers the data phase of a flash page-program command and then commits it to one page of the array. A shared decode front-end recognises the opcode and the 24-bit address. It raises `pp_start_i` with the address and then passes each following data bit on `bit_valid_i`/`bit_i`. The block packs the bits into bytes and stores them in a page-sized buffer, starting at the address offset and moving upward. A valid bit is kept for each offset.

When the front-end reports the end of selection on `cs_rise_i`, the block decides whether to commit. It commits only if a whole number of bytes arrived, at least one byte was loaded, writes are enabled and the page is not protected. The protection lookup is done outside the block and arrives on `prot_hit_i`. A committed cycle walks through the page. It reads every byte from the array and writes back the AND of the old byte and the buffered byte, but only at offsets that were loaded. `busy_o` stays high for a fixed number of clocks that stands in for the real program time. In the last busy cycle the block pulses `wen_clr_o` so that the write-enable latch is cleared.

Top module: `pp_load_buf`

## Requirements
- R1: The page number is taken from address bits [OFF_W +: PAGE_W] (A18..A8 by default) and the start offset from bits [OFF_W-1:0]. All address bits above the page field have no effect.
- R2: Data bits arrive most significant bit first, eight to a byte. Successive bytes are stored at successive offsets starting at the start offset, and the offset wraps from the top of the page back to 0 within the same page.
- R3: When more bytes are loaded than the page holds, each offset keeps the last byte written to it, so the last PAGE_BYTES bytes are the ones programmed.
- R4: At `cs_rise_i` a program cycle starts only if the bit count is a multiple of 8, `wen_i` is 1 and `prot_hit_i` is 0. Otherwise the load is dropped, no array write occurs and `busy_o` stays 0.
- R5: On a commit, `busy_o` rises in the cycle after `cs_rise_i` and stays high for exactly PROG_CYCLES clock cycles.
- R6: `wen_clr_o` pulses once, in the last busy cycle of a committed program. It never pulses for a rejected command.
- R7: Each loaded offset is written with (old array byte AND buffered byte). Offsets that were not loaded, and all other pages, are left unchanged.
- R8: `pp_start_i`, data bits and `cs_rise_i` that arrive while `busy_o` is 1 are ignored. They start no second program cycle and cause no writes.
- R9: After reset, `busy_o`, `wen_clr_o` and `arr_we_o` are 0.
- R10: A `cs_rise_i` that arrives with zero data bytes loaded starts no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pp_start_i | input | 1 | Page-program command and address decoded |
| pp_addr_i | input | ADDR_W | Command address, valid with pp_start_i |
| bit_valid_i | input | 1 | One data bit present on bit_i |
| bit_i | input | 1 | Serial data bit, MSB of each byte first |
| cs_rise_i | input | 1 | End of chip select, one-cycle pulse |
| wen_i | input | 1 | Write-enable latch state |
| prot_hit_i | input | 1 | Target page lies in a protected area |
| busy_o | output | 1 | Program cycle in progress (ready/busy bit) |
| wen_clr_o | output | 1 | Clear the write-enable latch |
| arr_raddr_o | output | PAGE_W+OFF_W | Array read address, data one cycle later |
| arr_rdata_i | input | BYTE_W | Array read data |
| arr_we_o | output | 1 | Array write strobe |
| arr_waddr_o | output | PAGE_W+OFF_W | Array write address |
| arr_wdata_o | output | BYTE_W | Array write data |

## Verification
The assertions check the following on every cycle. Each busy period lasts exactly PROG_CYCLES clocks. The clear pulse falls in the last busy cycle. Array writes happen only while busy and never set a bit that was clear in the old byte. A busy period starts only right after an end of select that saw writes enabled and no protection. The page under write stays fixed for the whole busy period. Other behaviour can only be shown by the bench scenarios, where a shadow of the array is compared after each command. These cover the wrap of the offset, the last-bytes-win rule on overlong loads, rejection on a partial byte, on an empty load, on a disabled write and on a protected page, and commands injected during a busy period.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pp_state_e;
endpackage

// File: rtl/pp_byte_asm.sv
module pp_byte_asm #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              aligned_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (bit_valid_i) begin
      sh_q  <= {sh_q[BYTE_W-3:0], bit_i};
      cnt_q <= (cnt_q == CNT_W'(BYTE_W-1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign byte_valid_o = bit_valid_i && (cnt_q == CNT_W'(BYTE_W-1));
  assign byte_o       = {sh_q, bit_i};
  assign aligned_o    = (cnt_q == '0);
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int OFF_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  localparam int BYTES = 1 << OFF_W;

  logic [BYTE_W-1:0] data_q [BYTES];
  logic [BYTES-1:0]  vld_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_off_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (clear_i) vld_q <= '0;
    else if (wr_en_i) vld_q[wr_off_i] <= 1'b1;
  end

  assign rd_data_o = data_q[rd_off_i];
  assign rd_vld_o  = vld_q[rd_off_i];
  assign any_vld_o = |vld_q;
endmodule

// File: rtl/pp_prog_seq.sv
module pp_prog_seq #(
  parameter int OFF_W       = 8,
  parameter int PROG_CYCLES = 500000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [OFF_W-1:0] rd_off_o,
  output logic             wr_pend_o,
  output logic [OFF_W-1:0] wr_off_o
);
  localparam int BYTES = 1 << OFF_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             rd_act;

  assign rd_act = busy_q && (cnt_q < CNT_W'(BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      wr_pend_o <= 1'b0;
      wr_off_o  <= '0;
    end else begin
      wr_pend_o <= rd_act;
      wr_off_o  <= cnt_q[OFF_W-1:0];
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (done_o) busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = busy_q && (cnt_q == CNT_W'(PROG_CYCLES - 1));
  assign rd_off_o = cnt_q[OFF_W-1:0];
endmodule

// File: rtl/pp_load_buf.sv
module pp_load_buf #(
  parameter int ADDR_W      = 24,
  parameter int PAGE_W      = 11,
  parameter int OFF_W       = 8,
  parameter int BYTE_W      = 8,
  parameter int PROG_CYCLES = 500000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pp_start_i,
  input  logic [ADDR_W-1:0]       pp_addr_i,
  input  logic                    bit_valid_i,
  input  logic                    bit_i,
  input  logic                    cs_rise_i,
  input  logic                    wen_i,
  input  logic                    prot_hit_i,
  output logic                    busy_o,
  output logic                    wen_clr_o,
  output logic [PAGE_W+OFF_W-1:0] arr_raddr_o,
  input  logic [BYTE_W-1:0]       arr_rdata_i,
  output logic                    arr_we_o,
  output logic [PAGE_W+OFF_W-1:0] arr_waddr_o,
  output logic [BYTE_W-1:0]       arr_wdata_o
);
  import pp_pkg::*;

  localparam int ARR_W = PAGE_W + OFF_W;

  pp_state_e         state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  logic              bit_en, asm_clr, byte_vld, aligned;
  logic [BYTE_W-1:0] byte_d;
  logic              buf_clr, any_vld, buf_vld;
  logic [BYTE_W-1:0] buf_data;
  logic              commit, seq_start, seq_busy, seq_done, wr_pend;
  logic [OFF_W-1:0]  rd_off, wr_off;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^pp_addr_i[ADDR_W-1:ARR_W];

  // bits that coincide with end of select are dropped
  assign bit_en  = (state_q == ST_LOAD) && bit_valid_i && !cs_rise_i;
  assign asm_clr = (state_q != ST_LOAD);
  assign buf_clr = (state_q == ST_IDLE) && pp_start_i;

  pp_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (asm_clr),
    .bit_valid_i  (bit_en),
    .bit_i        (bit_i),
    .byte_valid_o (byte_vld),
    .byte_o       (byte_d),
    .aligned_o    (aligned)
  );

  pp_page_buf #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (buf_clr),
    .wr_en_i   (byte_vld),
    .wr_off_i  (off_q),
    .wr_data_i (byte_d),
    .rd_off_i  (wr_off),
    .rd_data_o (buf_data),
    .rd_vld_o  (buf_vld),
    .any_vld_o (any_vld)
  );

  assign commit    = aligned && any_vld && wen_i && !prot_hit_i;
  assign seq_start = (state_q == ST_LOAD) && cs_rise_i && commit;

  pp_prog_seq #(.OFF_W(OFF_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (seq_start),
    .busy_o    (seq_busy),
    .done_o    (seq_done),
    .rd_off_o  (rd_off),
    .wr_pend_o (wr_pend),
    .wr_off_o  (wr_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pp_start_i) begin
          state_q <= ST_LOAD;
          page_q  <= pp_addr_i[OFF_W +: PAGE_W];
          off_q   <= pp_addr_i[OFF_W-1:0];
        end
        ST_LOAD: begin
          if (cs_rise_i)     state_q <= commit ? ST_PROG : ST_IDLE;
          else if (byte_vld) off_q   <= off_q + 1'b1;
        end
        ST_PROG: if (seq_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = seq_busy;
  assign wen_clr_o   = seq_done;
  assign arr_raddr_o = {page_q, rd_off};
  assign arr_we_o    = wr_pend && buf_vld;
  assign arr_waddr_o = {page_q, wr_off};
  assign arr_wdata_o = arr_rdata_i & buf_data;
endmodule

// File: rtl/pp_load_buf_chk.sv
module pp_load_buf_chk #(
  parameter int ARR_W       = 19,
  parameter int OFF_W       = 8,
  parameter int BYTE_W      = 8,
  parameter int PROG_CYCLES = 500000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_rise_i,
  input logic              wen_i,
  input logic              prot_hit_i,
  input logic              busy_o,
  input logic              wen_clr_o,
  input logic [BYTE_W-1:0] arr_rdata_i,
  input logic              arr_we_o,
  input logic [ARR_W-1:0]  arr_waddr_o,
  input logic [BYTE_W-1:0] arr_wdata_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && run_q != 0) |-> run_q == 32'(PROG_CYCLES));
  // R5
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < 32'(PROG_CYCLES));
  // R5
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i));
  // R4
  busy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wen_i && !prot_hit_i));
  // R6
  wen_clr_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_o |-> busy_o);
  // R6
  wen_clr_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_clr_o |=> !busy_o);
  // R7
  write_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> (busy_o && ((arr_wdata_o & ~arr_rdata_i) == '0)));
  // R8
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && $past(arr_we_o)) |-> $stable(arr_waddr_o[ARR_W-1:OFF_W]));
endmodule

bind pp_load_buf pp_load_buf_chk #(
  .ARR_W(ARR_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_rise_i   (cs_rise_i),
  .wen_i       (wen_i),
  .prot_hit_i  (prot_hit_i),
  .busy_o      (busy_o),
  .wen_clr_o   (wen_clr_o),
  .arr_rdata_i (arr_rdata_i),
  .arr_we_o    (arr_we_o),
  .arr_waddr_o (arr_waddr_o),
  .arr_wdata_o (arr_wdata_o)
);

// File: tb/test_pp_load_buf.sv
module test_pp_load_buf;
  localparam int ADDR_W = 24;
  localparam int PAGE_W = 3;
  localparam int OFF_W  = 8;
  localparam int BYTE_W = 8;
  localparam int PROG   = 600;
  localparam int ARR_W  = PAGE_W + OFF_W;
  localparam int MEMN   = 1 << ARR_W;
  localparam int PB     = 1 << OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pp_start = 0, bv = 0, bt = 0, cs_rise = 0, wen = 0, prot = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic busy, wen_clr, we;
  logic [ARR_W-1:0] raddr, waddr;
  logic [7:0] rdata, wdata;

  logic [7:0] mem [MEMN];
  logic [7:0] exp_mem [MEMN];
  logic [7:0] ld [PB];
  bit         lv [PB];

  int total = 0, bad = 0;
  int n_busy = 0, n_wc = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 151) ^ (i >> 4) ^ 8'h5A) | 8'h81;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= init_val(i);
      rdata <= '0;
    end else begin
      rdata <= mem[raddr];
      if (we) mem[waddr] <= wdata;
    end
  end

  always @(negedge clk) begin
    if (busy) n_busy++;
    if (wen_clr) n_wc++;
  end

  pp_load_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
                .BYTE_W(BYTE_W), .PROG_CYCLES(PROG)) i_pp_load_buf (
    .clk_i(clk), .rst_ni(rst_n), .pp_start_i(pp_start), .pp_addr_i(addr),
    .bit_valid_i(bv), .bit_i(bt), .cs_rise_i(cs_rise), .wen_i(wen),
    .prot_hit_i(prot), .busy_o(busy), .wen_clr_o(wen_clr),
    .arr_raddr_o(raddr), .arr_rdata_i(rdata), .arr_we_o(we),
    .arr_waddr_o(waddr), .arr_wdata_o(wdata));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bv = 1'b1; bt = b;
    @(negedge clk); bv = 1'b0;
  endtask

  task automatic mem_cmp(input string tag);
    int miss = 0, first = -1;
    for (int i = 0; i < MEMN; i++)
      if (mem[i] !== exp_mem[i]) begin
        miss++;
        if (first < 0) first = i;
      end
    chk(miss == 0, tag, first < 0 ? 0 : int'(mem[first]),
        first < 0 ? 0 : int'(exp_mem[first]));
  endtask

  // inject: drive a foreign command while busy (R8)
  task automatic run_txn(input int page, input int off, input int nbytes,
                         input int extra_bits, input bit w, input bit p,
                         input bit inject, input bit last_ff);
    bit commit;
    int o;
    logic [7:0] d;
    for (int i = 0; i < PB; i++) lv[i] = 0;
    wen = w; prot = p;
    @(negedge clk);
    pp_start = 1'b1;
    addr = {$urandom()} [ADDR_W-1:0];
    addr[ARR_W-1:0] = {page[PAGE_W-1:0], off[OFF_W-1:0]};
    @(negedge clk); pp_start = 1'b0;
    o = off;
    for (int k = 0; k < nbytes; k++) begin
      d = (last_ff && k == nbytes - 1) ? 8'hFF : 8'($urandom());
      for (int b = 7; b >= 0; b--) send_bit(d[b]);
      ld[o] = d; lv[o] = 1; o = (o + 1) % PB;
    end
    for (int b = 0; b < extra_bits; b++) send_bit(1'($urandom()));
    commit = (extra_bits == 0) && (nbytes > 0) && w && !p;
    n_busy = 0; n_wc = 0;
    @(negedge clk); cs_rise = 1'b1;
    @(negedge clk); cs_rise = 1'b0;
    chk(busy === commit, "R4 R5 R10 busy after end of select", busy, commit);
    if (inject && commit) begin
      @(negedge clk); pp_start = 1'b1; addr = '0;
      @(negedge clk); pp_start = 1'b0;
      for (int b = 0; b < 8; b++) send_bit(1'b0);
      @(negedge clk); cs_rise = 1'b1;
      @(negedge clk); cs_rise = 1'b0;
    end
    for (int t = 0; t < PROG + 20 && busy; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    #1;
    chk(n_busy == (commit ? PROG : 0), "R5 busy length", n_busy, commit ? PROG : 0);
    chk(n_wc == (commit ? 1 : 0), "R6 wen clear pulses", n_wc, commit ? 1 : 0);
    chk(busy === 1'b0, "R8 no second cycle", busy, 0);
    if (commit)
      for (int i = 0; i < PB; i++)
        if (lv[i]) exp_mem[page * PB + i] = exp_mem[page * PB + i] & ld[i];
    mem_cmp("R1 R2 R3 R7 array contents");
  endtask

  initial begin
    int pg, of, nb;
    void'($urandom(32'd7741));
    for (int i = 0; i < MEMN; i++) exp_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk(busy === 0, "R9 busy at reset", busy, 0);
    chk(wen_clr === 0, "R9 wen_clr at reset", wen_clr, 0);
    chk(we === 0, "R9 no write at reset", we, 0);
    mem_cmp("R9 array untouched");
    // directed corner cases
    run_txn(2, 8'h10, 1, 0, 1, 0, 0, 0);     // single byte
    run_txn(5, 8'hF0, 40, 0, 1, 0, 0, 0);    // R2 wrap inside page
    run_txn(1, 8'h33, 300, 0, 1, 0, 0, 0);   // R3 overlong load
    run_txn(3, 8'h00, 4, 3, 1, 0, 0, 0);     // R4 partial byte
    run_txn(3, 8'h00, 4, 0, 0, 0, 0, 0);     // R4 write disabled
    run_txn(4, 8'h80, 4, 0, 1, 1, 0, 0);     // R4 protected page
    run_txn(6, 8'h20, 0, 0, 1, 0, 0, 0);     // R10 empty load
    run_txn(7, 8'hFE, 5, 0, 1, 0, 1, 1);     // R8 command while busy
    // R7: all-ones byte keeps the old byte
    // constrained random
    for (int n = 0; n < 12; n++) begin
      pg = $urandom_range(0, (1 << PAGE_W) - 1);
      of = $urandom_range(0, PB - 1);
      nb = $urandom_range(0, 3) == 0 ? $urandom_range(200, 320) : $urandom_range(1, 20);
      run_txn(pg, of, nb, ($urandom_range(0, 5) == 0) ? $urandom_range(1, 7) : 0,
              $urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0,
              $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule